// File: doc/BRIEF.md
# Paired Data Address Comparator

This block watches the effective address of every data load or store and raises two debug-event hit flags, one for each of two 64-bit compare registers. A 2-bit mode input decides how the two registers are used. They can act as two independent exact-match addresses. They can act as a value and bit-mask pair. They can also bound a single address range, and a hit is then taken either inside that range or outside it.

An access is presented by pulsing the access-valid strobe together with the address. One cycle later, each hit flag that qualifies is high for exactly one cycle. In every mode except exact matching, the two flags describe one combined event, so they always rise and fall together. All address comparisons are unsigned and cover the full address width.

Top module: `dac_pair_match`

## Requirements
- R1: With mode 2'b00, hit 1 is set when the address equals register A, and hit 2 is set independently when the address equals register B.
- R2: With mode 2'b01, both hits are set when (address & B) == (A & B); register B is a bit mask, and a zero mask matches any address.
- R3: With mode 2'b10, both hits are set when A <= address < B. The lower bound is inclusive and the upper bound is exclusive.
- R4: With mode 2'b11, both hits are set when address < A or address >= B.
- R5: In modes 2'b01, 2'b10 and 2'b11, the two hit outputs are always equal.
- R6: All comparisons are unsigned over the full address width. An address with its top bit set is a large value, not a negative one.
- R7: No hit is produced in a cycle after which the access-valid strobe was low. Each strobed access gives hits for exactly one cycle.
- R8: Hits appear in the cycle after the clock edge that samples the access. Nothing is visible before that edge.
- R9: A synchronous active-high reset clears both hits, and no hit is set in the cycle after a reset edge.
- R10: When A >= B, mode 2'b10 never hits and mode 2'b11 hits on every strobed access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_vld | input | 1 | Access-valid strobe for the current data access |
| acc_addr | input | ADDR_W | Effective address of the access |
| cmp_a | input | ADDR_W | Compare register A |
| cmp_b | input | ADDR_W | Compare register B |
| cmp_mode | input | 2 | Compare mode: 00 exact, 01 masked, 10 inside range, 11 outside range |
| hit_a | output | 1 | Registered hit for register A |
| hit_b | output | 1 | Registered hit for register B |

## Verification
The embedded assertions check several properties on every cycle. They confirm that the paired modes keep both flags equal, that no flag follows an unstrobed cycle, that reset clears the outputs, and that the exact mode tracks each register separately. They also confirm that an inverted range gives no hits when inside and always hits when outside. Only the bench's scenarios can show that the inclusive and exclusive range edges fall on the correct addresses. The same holds for the unsigned treatment of top-bit addresses, the masked compare, and the timing of the single-cycle pulse against the strobe.

// File: rtl/dac_pkg.sv
package dac_pkg;
  typedef enum logic [1:0] {
    MODE_EXACT   = 2'b00,
    MODE_MASKED  = 2'b01,
    MODE_INSIDE  = 2'b10,
    MODE_OUTSIDE = 2'b11
  } dac_mode_e;

  typedef struct packed {
    logic eq_a;
    logic eq_b;
    logic mask_eq;
    logic ge_a;
    logic lt_b;
  } dac_cmp_t;
endpackage

// File: rtl/dac_addr_cmp.sv
module dac_addr_cmp
  import dac_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] reg_a,
  input  logic [ADDR_W-1:0] reg_b,
  output dac_cmp_t          res
);
  localparam int NREG = 2;

  logic [ADDR_W-1:0] regs [NREG];
  logic [NREG-1:0]   eq_vec;

  assign regs[0] = reg_a;
  assign regs[1] = reg_b;

  // one exact comparator per register
  for (genvar g = 0; g < NREG; g++) begin : g_eq
    assign eq_vec[g] = (addr == regs[g]);
  end

  always_comb begin
    res.eq_a    = eq_vec[0];
    res.eq_b    = eq_vec[1];
    res.mask_eq = ((addr ^ reg_a) & reg_b) == '0;
    // unsigned magnitude compares over the whole width
    res.ge_a    = (addr >= reg_a);
    res.lt_b    = (addr < reg_b);
  end
endmodule

// File: rtl/dac_mode_sel.sv
module dac_mode_sel
  import dac_pkg::*;
(
  input  dac_mode_e mode,
  input  dac_cmp_t  cmp,
  output logic      sel_a,
  output logic      sel_b
);
  logic paired;

  always_comb begin
    paired = 1'b0;
    sel_a  = 1'b0;
    sel_b  = 1'b0;
    unique case (mode)
      MODE_EXACT: begin
        sel_a = cmp.eq_a;
        sel_b = cmp.eq_b;
      end
      MODE_MASKED:  paired = cmp.mask_eq;
      MODE_INSIDE:  paired = cmp.ge_a & cmp.lt_b;
      MODE_OUTSIDE: paired = ~cmp.ge_a | ~cmp.lt_b;
      default:      paired = 1'b0;
    endcase
    if (mode != MODE_EXACT) begin
      sel_a = paired;
      sel_b = paired;
    end
  end
endmodule

// File: rtl/dac_pair_match.sv
module dac_pair_match
  import dac_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_vld,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [ADDR_W-1:0] cmp_a,
  input  logic [ADDR_W-1:0] cmp_b,
  input  logic [1:0]        cmp_mode,
  output logic              hit_a,
  output logic              hit_b
);
  dac_cmp_t cmp;
  logic     sel_a, sel_b;

  dac_addr_cmp #(.ADDR_W(ADDR_W)) u_cmp (
    .addr  (acc_addr),
    .reg_a (cmp_a),
    .reg_b (cmp_b),
    .res   (cmp)
  );

  dac_mode_sel u_sel (
    .mode  (dac_mode_e'(cmp_mode)),
    .cmp   (cmp),
    .sel_a (sel_a),
    .sel_b (sel_b)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_a <= 1'b0;
      hit_b <= 1'b0;
    end else begin
      hit_a <= acc_vld & sel_a;
      hit_b <= acc_vld & sel_b;
    end
  end

  // R9: reset clears both hits on the next cycle
  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (!hit_a && !hit_b));

  // R7: no hit follows a cycle without a strobe
  a_r7_no_strobe_no_hit: assert property (@(posedge clk) disable iff (rst)
    !acc_vld |=> (!hit_a && !hit_b));

  // R5: paired modes keep both flags equal
  a_r5_paired_equal: assert property (@(posedge clk) disable iff (rst)
    (acc_vld && cmp_mode != 2'b00) |=> (hit_a == hit_b));

  // R1: exact mode tracks each register separately
  a_r1_exact_a: assert property (@(posedge clk) disable iff (rst)
    (acc_vld && cmp_mode == 2'b00) |=> (hit_a == $past(acc_addr == cmp_a)));
  a_r1_exact_b: assert property (@(posedge clk) disable iff (rst)
    (acc_vld && cmp_mode == 2'b00) |=> (hit_b == $past(acc_addr == cmp_b)));

  // R10: inverted range is empty inside, total outside
  a_r10_empty_inside: assert property (@(posedge clk) disable iff (rst)
    (acc_vld && cmp_mode == 2'b10 && cmp_a >= cmp_b) |=> !hit_a);
  a_r10_full_outside: assert property (@(posedge clk) disable iff (rst)
    (acc_vld && cmp_mode == 2'b11 && cmp_a >= cmp_b) |=> (hit_a && hit_b));
endmodule

// File: tb/sim_dac_pair_match.sv
module sim_dac_pair_match;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 64;
  localparam int NV = 20;
  localparam int VW = 2 + 3*AW + 2;

  // vector layout: {mode, addr, A, B, exp_a, exp_b}
  localparam logic [VW-1:0] VEC [NV] = '{
    {2'b00, 64'd100, 64'd100, 64'd200, 2'b10},                  // R1
    {2'b00, 64'd200, 64'd100, 64'd200, 2'b01},                  // R1
    {2'b00, 64'd5,   64'd5,   64'd5,   2'b11},                  // R1
    {2'b00, 64'd7,   64'd5,   64'd6,   2'b00},                  // R1
    {2'b01, 64'h1234, 64'h1200, 64'hFF00, 2'b11},               // R2
    {2'b01, 64'h1334, 64'h1200, 64'hFF00, 2'b00},               // R2
    {2'b01, 64'hDEAD, 64'hBEEF, 64'h0, 2'b11},                  // R2 zero mask
    {2'b10, 64'd100, 64'd100, 64'd200, 2'b11},                  // R3 low edge
    {2'b10, 64'd200, 64'd100, 64'd200, 2'b00},                  // R3 high edge
    {2'b10, 64'd199, 64'd100, 64'd200, 2'b11},                  // R3
    {2'b10, 64'd99,  64'd100, 64'd200, 2'b00},                  // R3
    {2'b11, 64'd99,  64'd100, 64'd200, 2'b11},                  // R4
    {2'b11, 64'd200, 64'd100, 64'd200, 2'b11},                  // R4
    {2'b11, 64'd100, 64'd100, 64'd200, 2'b00},                  // R4
    {2'b10, 64'h8000_0000_0000_0000, 64'h10, 64'hFFFF_FFFF_FFFF_FFF0, 2'b11}, // R6
    {2'b11, 64'hFFFF_FFFF_FFFF_FFFE, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 2'b00},  // R6
    {2'b10, 64'd200, 64'd300, 64'd100, 2'b00},                  // R10
    {2'b11, 64'd200, 64'd300, 64'd100, 2'b11},                  // R10
    {2'b10, 64'd50,  64'd50,  64'd50,  2'b00},                  // R10
    {2'b11, 64'd50,  64'd50,  64'd50,  2'b11}                   // R10
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          acc_vld = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [AW-1:0] cmp_a = '0;
  logic [AW-1:0] cmp_b = '0;
  logic [1:0]    cmp_mode = 2'b00;
  logic          hit_a, hit_b;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_pair_match #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .acc_vld(acc_vld), .acc_addr(acc_addr),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_mode(cmp_mode),
    .hit_a(hit_a), .hit_b(hit_b)
  );

  task automatic check(input string req, input logic [1:0] got, input logic [1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s hits=%b expected=%b", req, got, exp);
    end
  endtask

  // drive one strobed access, then look at the hits one edge later
  task automatic access(input logic [1:0] m, input logic [AW-1:0] a,
                        input logic [AW-1:0] ra, input logic [AW-1:0] rb,
                        input logic v);
    @(negedge clk);
    cmp_mode = m; acc_addr = a; cmp_a = ra; cmp_b = rb; acc_vld = v;
    @(negedge clk);
    acc_vld = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog hits=%b expected=done", {hit_a, hit_b});
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset state", {hit_a, hit_b}, 2'b00);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      access(v[VW-1 -: 2], v[VW-3 -: AW], v[VW-3-AW -: AW], v[VW-3-2*AW -: AW], 1'b1);
      check($sformatf("R1-R6/R10 vector %0d", i), {hit_a, hit_b}, v[1:0]);
    end

    // R7: matching inputs without strobe give nothing
    access(2'b00, 64'd42, 64'd42, 64'd42, 1'b0);
    check("R7 no strobe", {hit_a, hit_b}, 2'b00);

    // R7: pulse lasts one cycle only
    access(2'b11, 64'd1, 64'd100, 64'd200, 1'b1);
    check("R7 pulse high", {hit_a, hit_b}, 2'b11);
    @(negedge clk);
    check("R7 pulse ends", {hit_a, hit_b}, 2'b00);

    // R8: not visible before the sampling edge
    @(negedge clk);
    cmp_mode = 2'b00; acc_addr = 64'd9; cmp_a = 64'd9; cmp_b = 64'd9; acc_vld = 1'b1;
    #1;
    check("R8 before edge", {hit_a, hit_b}, 2'b00);
    @(negedge clk);
    acc_vld = 1'b0;
    check("R8 after edge", {hit_a, hit_b}, 2'b11);

    // R9: reset wins over a matching strobe
    @(negedge clk);
    acc_vld = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R9 reset over strobe", {hit_a, hit_b}, 2'b00);
    acc_vld = 1'b0; rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule